// File: doc/BRIEF.md
# Timestamped Input Event Collector

The collector records input events from several channels. A free-running timestamp counter stamps each event at the clock edge where the channel's strobe is sampled. The timestamp and the event data go into that channel's own small FIFO. If a channel receives more events than its FIFO can hold, the extra events are discarded and a sticky overflow flag is set for that channel.

A host reads events with a one-cycle read command. The command carries a channel number and an absolute deadline on the counter's time scale. The read stays pending, and the busy bit stays high, until one of three things happens:

- the selected channel reports its overflow, which also clears the flag and empties the FIFO;
- the oldest event in the FIFO is handed over;
- the counter reaches the deadline while the FIFO is still empty.

The host polls the three-bit status until the busy bit clears, then takes the result.

Top module: `ic_collector`

## Requirements
- R1: After reset the status is 000 and the counter output is 0. The counter then increases by exactly one on every clock edge.
- R2: An event is stored with the counter value present at the edge where its strobe is sampled. Each channel holds up to DEPTH events (default 4) and returns them oldest first.
- R3: A read starts only when `host_cmd` is 2'b01 at a clock edge; codes 00, 10 and 11 do nothing. The channel and deadline are sampled at that same edge. From the next cycle the status reads 100 (bit 2 = busy) until the read completes.
- R4: If the selected channel holds an event when the read starts, the read completes one edge later. The status becomes 000, `rd_ts` and `rd_data` show the oldest event, and that event is removed.
- R5: A read on an empty channel waits. If an event arrives before the deadline, the read completes with that event and status 000.
- R6: A read on an empty channel completes at the first edge where the counter, compared unsigned at full width, is greater than or equal to the deadline. The status becomes 001 (bit 0 = timeout) and no event is removed. A deadline already in the past makes the read complete one edge after it starts.
- R7: A strobe that finds its FIFO full, with no pop in that cycle, is dropped and sets the channel's overflow flag. The next read on that channel completes with status 010 (bit 1 = overflow), whatever the FIFO holds. That completion clears the flag and empties the FIFO.
- R8: A strobe and a pop on a full FIFO in the same cycle are both carried out. The new event is kept and no overflow is raised.
- R9: A read command that arrives while a read is pending is ignored. Its channel and deadline have no effect.
- R10: While no read is pending and none starts, `rd_status`, `rd_ts` and `rd_data` keep their last values. At most one of status bits 1 and 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_stb | input | NUM_CH | Per-channel event strobe |
| ev_data | input | NUM_CH*DATA_W | Per-channel event data; channel i uses bits [i*DATA_W +: DATA_W] |
| host_cmd | input | 2 | Host command: 01 read, anything else no operation |
| host_chan | input | CH_W | Channel to read, sampled with the read command |
| host_deadline | input | TS_W | Absolute timeout timestamp, sampled with the read command |
| now_ts | output | TS_W | Current value of the coarse timestamp counter |
| rd_status | output | 3 | Bit 2 busy, bit 1 overflow, bit 0 timeout |
| rd_ts | output | TS_W | Timestamp of the last event read |
| rd_data | output | DATA_W | Data of the last event read |

## Verification
Two functions can fall in the same clock edge: a new strobe on a channel whose FIFO is full, and the pop that a completing read performs on that same channel. The bench fills one channel to its limit and starts a read on it. It times the strobe to land exactly on the edge where the pop occurs. The case is judged by reading out every entry that follows: the new event must appear last, in its place in the order, and no overflow status may appear.

// File: rtl/ic_pkg.sv
package ic_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_READ = 2'b01
    } host_cmd_e;

    localparam int ST_TIMEOUT  = 0;
    localparam int ST_OVERFLOW = 1;
    localparam int ST_BUSY     = 2;

endpackage

// File: rtl/ic_chan_fifo.sv
module ic_chan_fifo #(
    parameter int DEPTH  = 4,
    parameter int TS_W   = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [TS_W-1:0]   push_ts,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic              empty,
    output logic              ovf,
    output logic [TS_W-1:0]   head_ts,
    output logic [DATA_W-1:0] head_data
);
    localparam int ENT_W = TS_W + DATA_W;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] mem;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
        logic                        ovf;
    } fifo_st_t;

    fifo_st_t st_q, st_d;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    logic is_full, do_pop, do_push;
    logic [ENT_W-1:0] entry;

    always_comb begin
        st_d    = st_q;
        entry   = {push_ts, push_data};
        is_full = (st_q.cnt == CNT_W'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && (!is_full || do_pop);
        if (flush) begin
            st_d.ovf = 1'b0;
            st_d.rd  = '0;
            if (push) begin
                st_d.mem[0] = entry;
                st_d.wr     = ptr_next('0);
                st_d.cnt    = CNT_W'(1);
            end else begin
                st_d.wr  = '0;
                st_d.cnt = '0;
            end
        end else begin
            if (push && !do_push) begin
                st_d.ovf = 1'b1;
            end
            if (do_push) begin
                st_d.mem[st_q.wr] = entry;
                st_d.wr           = ptr_next(st_q.wr);
            end
            if (do_pop) begin
                st_d.rd = ptr_next(st_q.rd);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
                2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign empty     = (st_q.cnt == '0);
    assign ovf       = st_q.ovf;
    assign head_ts   = st_q.mem[st_q.rd][ENT_W-1:DATA_W];
    assign head_data = st_q.mem[st_q.rd][DATA_W-1:0];

endmodule

// File: rtl/ic_read_ctrl.sv
module ic_read_ctrl
    import ic_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int TS_W   = 16,
    parameter int DATA_W = 8,
    parameter int CH_W   = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    cmd,
    input  logic [CH_W-1:0]               cmd_chan,
    input  logic [TS_W-1:0]               cmd_deadline,
    input  logic [TS_W-1:0]               now,
    input  logic [NUM_CH-1:0]             ch_empty,
    input  logic [NUM_CH-1:0]             ch_ovf,
    input  logic [NUM_CH-1:0][TS_W-1:0]   ch_ts,
    input  logic [NUM_CH-1:0][DATA_W-1:0] ch_data,
    output logic [NUM_CH-1:0]             ch_pop,
    output logic [NUM_CH-1:0]             ch_flush,
    output logic [2:0]                    status,
    output logic [TS_W-1:0]               res_ts,
    output logic [DATA_W-1:0]             res_data
);
    typedef struct packed {
        logic [2:0]        status;
        logic [CH_W-1:0]   chan;
        logic [TS_W-1:0]   deadline;
        logic [TS_W-1:0]   ts;
        logic [DATA_W-1:0] data;
    } rd_st_t;

    rd_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        ch_pop   = '0;
        ch_flush = '0;
        if (!st_q.status[ST_BUSY]) begin
            if (cmd == CMD_READ) begin
                st_d.status   = 3'b100;
                st_d.chan     = cmd_chan;
                st_d.deadline = cmd_deadline;
            end
        end else if (ch_ovf[st_q.chan]) begin
            ch_flush[st_q.chan] = 1'b1;
            st_d.status         = 3'b010;
        end else if (!ch_empty[st_q.chan]) begin
            ch_pop[st_q.chan] = 1'b1;
            st_d.status       = 3'b000;
            st_d.ts           = ch_ts[st_q.chan];
            st_d.data         = ch_data[st_q.chan];
        end else if (now >= st_q.deadline) begin
            st_d.status = 3'b001;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status   = st_q.status;
    assign res_ts   = st_q.ts;
    assign res_data = st_q.data;

endmodule

// File: rtl/ic_collector.sv
module ic_collector #(
    parameter int NUM_CH = 2,
    parameter int DEPTH  = 4,
    parameter int TS_W   = 16,
    parameter int DATA_W = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        ev_stb,
    input  logic [NUM_CH*DATA_W-1:0] ev_data,
    input  logic [1:0]               host_cmd,
    input  logic [CH_W-1:0]          host_chan,
    input  logic [TS_W-1:0]          host_deadline,
    output logic [TS_W-1:0]          now_ts,
    output logic [2:0]               rd_status,
    output logic [TS_W-1:0]          rd_ts,
    output logic [DATA_W-1:0]        rd_data
);
    logic [TS_W-1:0] ts_q, ts_d;

    always_comb begin
        ts_d = ts_q + TS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    assign now_ts = ts_q;

    logic [NUM_CH-1:0]             ch_empty, ch_ovf, ch_pop, ch_flush;
    logic [NUM_CH-1:0][TS_W-1:0]   ch_ts;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_data;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        ic_chan_fifo #(
            .DEPTH (DEPTH),
            .TS_W  (TS_W),
            .DATA_W(DATA_W)
        ) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (ev_stb[i]),
            .push_ts  (ts_q),
            .push_data(ev_data[i*DATA_W +: DATA_W]),
            .pop      (ch_pop[i]),
            .flush    (ch_flush[i]),
            .empty    (ch_empty[i]),
            .ovf      (ch_ovf[i]),
            .head_ts  (ch_ts[i]),
            .head_data(ch_data[i])
        );
    end

    ic_read_ctrl #(
        .NUM_CH(NUM_CH),
        .TS_W  (TS_W),
        .DATA_W(DATA_W),
        .CH_W  (CH_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (host_cmd),
        .cmd_chan    (host_chan),
        .cmd_deadline(host_deadline),
        .now         (ts_q),
        .ch_empty    (ch_empty),
        .ch_ovf      (ch_ovf),
        .ch_ts       (ch_ts),
        .ch_data     (ch_data),
        .ch_pop      (ch_pop),
        .ch_flush    (ch_flush),
        .status      (rd_status),
        .res_ts      (rd_ts),
        .res_data    (rd_data)
    );

endmodule

// File: rtl/ic_collector_chk.sv
module ic_collector_chk #(
    parameter int TS_W   = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        host_cmd,
    input logic [TS_W-1:0]   now_ts,
    input logic [2:0]        rd_status,
    input logic [TS_W-1:0]   rd_ts,
    input logic [DATA_W-1:0] rd_data
);
    logic start;
    assign start = (host_cmd == 2'b01);

    assert_counter_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> now_ts == $past(now_ts) + TS_W'(1));

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_status[2] && start) |=> rd_status == 3'b100);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_status[2] && !start) |=> $stable(rd_status) && $stable(rd_ts) && $stable(rd_data));

    assert_err_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_status[1:0]));

    assert_busy_no_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status[2] |-> rd_status[1:0] == 2'b00);

endmodule

bind ic_collector ic_collector_chk #(
    .TS_W  (TS_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_cmd (host_cmd),
    .now_ts   (now_ts),
    .rd_status(rd_status),
    .rd_ts    (rd_ts),
    .rd_data  (rd_data)
);

// File: tb/ic_collector_test.sv
`timescale 1ns/1ps
module ic_collector_test;
    localparam int NUM_CH = 2;
    localparam int TS_W   = 16;
    localparam int DATA_W = 8;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NUM_CH-1:0]        ev_stb = '0;
    logic [NUM_CH*DATA_W-1:0] ev_data = '0;
    logic [1:0]               host_cmd = 2'b00;
    logic [0:0]               host_chan = '0;
    logic [TS_W-1:0]          host_deadline = '0;
    logic [TS_W-1:0]          now_ts;
    logic [2:0]               rd_status;
    logic [TS_W-1:0]          rd_ts;
    logic [DATA_W-1:0]        rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ic_collector #(.NUM_CH(NUM_CH), .DEPTH(4), .TS_W(TS_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .ev_stb(ev_stb), .ev_data(ev_data),
        .host_cmd(host_cmd), .host_chan(host_chan), .host_deadline(host_deadline),
        .now_ts(now_ts), .rd_status(rd_status), .rd_ts(rd_ts), .rd_data(rd_data)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input int ch, input logic [7:0] d, output logic [TS_W-1:0] ts);
        ev_stb[ch] = 1'b1;
        ev_data[ch*DATA_W +: DATA_W] = d;
        ts = now_ts;
        tick();
        ev_stb[ch] = 1'b0;
    endtask

    // Issues a read, checks busy in the cycle after, waits for completion.
    task automatic do_read(input int ch, input logic [TS_W-1:0] dl, input string req,
                           output logic [2:0] st, output logic [TS_W-1:0] ts_cmd,
                           output int polls);
        host_cmd = 2'b01;
        host_chan = ch[0:0];
        host_deadline = dl;
        ts_cmd = now_ts;
        tick();
        host_cmd = 2'b00;
        check(req, "busy after command R3", {29'b0, rd_status}, 32'h4);
        polls = 0;
        while (rd_status[2] && polls < 500) begin
            tick();
            polls++;
        end
        st = rd_status;
    endtask

    task automatic t_reset();
        check("R1", "status after reset", {29'b0, rd_status}, 0);
        check("R1", "counter after reset", {16'b0, now_ts}, 0);
        rst_n = 1'b1;
        tick();
        check("R1", "counter after one edge", {16'b0, now_ts}, 1);
        tick();
        check("R1", "counter after two edges", {16'b0, now_ts}, 2);
    endtask

    task automatic t_single();
        logic [TS_W-1:0] ets, tc; logic [2:0] st; int p;
        push(0, 8'h5A, ets);
        tick();
        do_read(0, 16'hFFFF, "R4", st, tc, p);
        check("R4", "status", {29'b0, st}, 0);
        check("R4", "one cycle", p, 1);
        check("R2", "timestamp", {16'b0, rd_ts}, {16'b0, ets});
        check("R4", "data", {24'b0, rd_data}, 32'h5A);
    endtask

    task automatic t_order();
        logic [TS_W-1:0] e0, e1, e2, tc; logic [2:0] st; int p;
        push(1, 8'h11, e0);
        tick();
        push(1, 8'h22, e1);
        push(1, 8'h33, e2);
        do_read(1, 16'hFFFF, "R2", st, tc, p);
        check("R2", "first data", {24'b0, rd_data}, 32'h11);
        check("R2", "first ts", {16'b0, rd_ts}, {16'b0, e0});
        do_read(1, 16'hFFFF, "R2", st, tc, p);
        check("R2", "second data", {24'b0, rd_data}, 32'h22);
        check("R2", "second ts", {16'b0, rd_ts}, {16'b0, e1});
        do_read(1, 16'hFFFF, "R2", st, tc, p);
        check("R2", "third data", {24'b0, rd_data}, 32'h33);
        check("R2", "third ts", {16'b0, rd_ts}, {16'b0, e2});
    endtask

    task automatic t_timeout();
        logic [TS_W-1:0] dl, tc, ets; logic [2:0] st; int p;
        dl = now_ts + 16'd12;
        do_read(0, dl, "R6", st, tc, p);
        check("R6", "timeout status", {29'b0, st}, 1);
        check("R6", "completion time", {16'b0, now_ts}, {16'b0, dl + 16'd1});
        check("R10", "data held on timeout", {24'b0, rd_data}, 32'h33);
        dl = now_ts - 16'd3;
        do_read(0, dl, "R6", st, tc, p);
        check("R6", "past deadline status", {29'b0, st}, 1);
        check("R6", "past deadline one cycle", p, 1);
        // An event on channel 1 is untouched by a timeout on channel 0.
        push(1, 8'h44, ets);
        do_read(0, now_ts + 16'd2, "R6", st, tc, p);
        check("R6", "timeout ch0", {29'b0, st}, 1);
        do_read(1, 16'hFFFF, "R6", st, tc, p);
        check("R6", "event kept", {24'b0, rd_data}, 32'h44);
        check("R6", "event ts kept", {16'b0, rd_ts}, {16'b0, ets});
    endtask

    task automatic t_wait_event();
        logic [TS_W-1:0] ets, tc; logic [2:0] st; int p;
        host_cmd = 2'b01; host_chan = 1'b0; host_deadline = now_ts + 16'd100;
        tick();
        host_cmd = 2'b00;
        repeat (5) tick();
        check("R5", "still busy", {29'b0, rd_status}, 4);
        push(0, 8'h77, ets);
        p = 0;
        while (rd_status[2] && p < 200) begin tick(); p++; end
        check("R5", "status", {29'b0, rd_status}, 0);
        check("R5", "data", {24'b0, rd_data}, 32'h77);
        check("R5", "ts", {16'b0, rd_ts}, {16'b0, ets});
        tc = '0; st = '0;
    endtask

    task automatic t_overflow();
        logic [TS_W-1:0] e, tc; logic [2:0] st; int p;
        for (int i = 0; i < 5; i++) push(0, 8'h80 + 8'(i), e);
        tick();
        do_read(0, 16'hFFFF, "R7", st, tc, p);
        check("R7", "overflow status", {29'b0, st}, 2);
        do_read(0, now_ts + 16'd4, "R7", st, tc, p);
        check("R7", "flushed then timeout", {29'b0, st}, 1);
        push(0, 8'h99, e);
        do_read(0, 16'hFFFF, "R7", st, tc, p);
        check("R7", "flag cleared", {29'b0, st}, 0);
        check("R7", "fresh data", {24'b0, rd_data}, 32'h99);
    endtask

    task automatic t_push_pop_full();
        logic [TS_W-1:0] e[5]; logic [TS_W-1:0] tc; logic [2:0] st; int p;
        for (int i = 0; i < 4; i++) push(1, 8'hA0 + 8'(i), e[i]);
        host_cmd = 2'b01; host_chan = 1'b1; host_deadline = 16'hFFFF;
        tick();
        host_cmd = 2'b00;
        ev_stb[1] = 1'b1; ev_data[DATA_W +: DATA_W] = 8'hA4; e[4] = now_ts;
        tick();
        ev_stb[1] = 1'b0;
        check("R8", "first status", {29'b0, rd_status}, 0);
        check("R8", "first data", {24'b0, rd_data}, 32'hA0);
        for (int i = 1; i < 5; i++) begin
            do_read(1, 16'hFFFF, "R8", st, tc, p);
            check("R8", "status no overflow", {29'b0, st}, 0);
            check("R8", "data order", {24'b0, rd_data}, 32'hA0 + i);
            check("R8", "ts order", {16'b0, rd_ts}, {16'b0, e[i]});
        end
    endtask

    task automatic t_ignore();
        logic [TS_W-1:0] dl; int p;
        dl = now_ts + 16'd20;
        host_cmd = 2'b01; host_chan = 1'b0; host_deadline = dl;
        tick();
        host_cmd = 2'b01; host_chan = 1'b1; host_deadline = 16'd0;
        tick();
        host_cmd = 2'b00;
        tick();
        check("R9", "second command ignored", {29'b0, rd_status}, 4);
        p = 0;
        while (rd_status[2] && p < 200) begin tick(); p++; end
        check("R9", "first deadline governs", {16'b0, now_ts}, {16'b0, dl + 16'd1});
        check("R9", "timeout status", {29'b0, rd_status}, 1);
        host_cmd = 2'b10;
        tick();
        host_cmd = 2'b11;
        tick();
        host_cmd = 2'b00;
        tick();
        check("R3", "other codes start nothing", {29'b0, rd_status}, 1);
        check("R10", "data held", {24'b0, rd_data}, 32'hA4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        t_reset();
        t_single();
        t_order();
        t_timeout();
        t_wait_event();
        t_overflow();
        t_push_pop_full();
        t_ignore();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule